// File: doc/BRIEF.md
# Completion-Restartable Clock Generator

This block paces a downstream processor with a strobe derived from a fast reference clock. Left alone, it emits a one-reference-cycle pulse at a fixed interval. When the processor reports that its current operation has finished, the block discards whatever part of the interval has already elapsed and emits a pulse at once. It then starts a fresh interval of the same length. The next operation can therefore begin as soon as the previous one completes. The fixed interval remains as a safety net for completions that are never reported, so it must be chosen longer than the slowest operation it paces.

The interval is modelled as a delay line made of `SECTIONS` chained sections, each with `STAGES` stages. Each stage lasts one reference cycle, so the interval is `SECTIONS*STAGES` cycles. A completion clears the whole line, which cancels any boundary still in flight. The completion input acts only on its low-to-high transition. An input that stays high therefore cannot hold the generator in permanent restart.

Top module: `restart_clock_gen`

## Requirements
- R1: While `rst_i` is high at a clock edge, `tick_o` is low in the following cycle and the delay line is emptied. After reset is released, the first pulse is high in the cycle after the P-th rising edge of `clk_i` with `rst_i` low, where P = SECTIONS*STAGES.
- R2: With no completion transitions, `tick_o` is high for exactly one cycle out of every P cycles.
- R3: A rising edge of `done_i` (sampled high at an edge, sampled low at the previous edge) makes `tick_o` high in the cycle after that edge.
- R4: A restart cancels the interval in progress. The next free-running pulse comes exactly P cycles after the restart pulse, and no pulse appears at the old boundary.
- R5: When a restart falls on the same edge as a natural interval boundary, exactly one single-cycle pulse results, and the next interval is P cycles long.
- R6: Only transitions of `done_i` count. A level that stays high, including one held high across reset release, causes no restart, and pulses continue every P cycles.
- R7: The period equals SECTIONS*STAGES reference cycles. Elaboration rejects parameter values with SECTIONS or STAGES below 1, or with a product below 2.
- R8: `tick_o` never stays high for two consecutive cycles unless a restart edge is sampled in the first of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast reference clock; one cycle is one delay stage |
| rst_i | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Completion indication from the paced processor; acts on its rising edge |
| tick_o | output | 1 | Pacing strobe, high for one reference cycle per boundary |

## Verification
The interesting collision is a completion edge that arrives on the same reference edge at which the delay line would wrap by itself. The bench provokes this by raising `done_i` exactly P-1 edges after the previous pulse. It then expects a single one-cycle pulse followed by a full P-cycle gap, not a doubled pulse or a shortened interval. A second near-collision raises `done_i` on the edge right after a natural pulse. There the two back-to-back pulses are legitimate, and the spacing that follows is checked to restart from the second one.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

   // Width of a counter that must hold values 0 .. modulus-1 (at least 1 bit)
   function automatic int unsigned cnt_width(input int unsigned modulus);
      int unsigned w;
      w = 1;
      while ((1 << w) < modulus) w++;
      return w;
   endfunction

endpackage

// File: rtl/rcg_edge_detect.sv
module rcg_edge_detect (
   input  logic clk_i,
   input  logic rst_i,
   input  logic level_i,
   output logic rise_o
);

   logic prev_q;

   // During reset the history follows the input, so a level already high
   // at release is not taken for a fresh completion.
   always_ff @(posedge clk_i) begin
      prev_q <= level_i;
   end

   assign rise_o = level_i && !prev_q && !rst_i;

endmodule

// File: rtl/rcg_mod_counter.sv
module rcg_mod_counter #(
   parameter int unsigned MOD = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   input  logic en_i,
   output logic carry_o
);

   localparam int unsigned W = rcg_pkg::cnt_width(MOD);

   generate
      if (MOD < 1) begin : g_bad_mod
         $error("rcg_mod_counter: MOD must be at least 1");
      end

      if (MOD == 1) begin : g_pass
         // A single-stage section passes every enable straight through
         assign carry_o = en_i;
      end else begin : g_count
         localparam logic [W-1:0] LAST = W'(MOD - 1);
         logic [W-1:0] cnt_q;
         logic         at_last;

         assign at_last = (cnt_q == LAST);
         assign carry_o = en_i && at_last;

         always_ff @(posedge clk_i) begin
            if (rst_i || clr_i) begin
               cnt_q <= '0;
            end else if (en_i) begin
               cnt_q <= at_last ? '0 : cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/restart_clock_gen.sv
module restart_clock_gen #(
   parameter int unsigned SECTIONS = 4,
   parameter int unsigned STAGES   = 5
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic done_i,
   output logic tick_o
);

   localparam int unsigned PERIOD = SECTIONS * STAGES;

   generate
      if (SECTIONS < 1 || STAGES < 1) begin : g_bad_dims
         $error("restart_clock_gen: SECTIONS and STAGES must be at least 1");
      end
      if (PERIOD < 2) begin : g_bad_period
         $error("restart_clock_gen: SECTIONS*STAGES must be at least 2");
      end
   endgenerate

   logic restart;
   logic stage_carry;
   logic line_wrap;
   logic tick_q;

   // R3 / R6: completion acts on its rising edge only
   rcg_edge_detect u_edge (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .level_i (done_i),
      .rise_o  (restart)
   );

   // Inner stages of one section: advance every reference cycle
   rcg_mod_counter #(.MOD(STAGES)) u_stage (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .clr_i   (restart),
      .en_i    (1'b1),
      .carry_o (stage_carry)
   );

   // Chain of sections: advance when a section has been traversed
   rcg_mod_counter #(.MOD(SECTIONS)) u_section (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .clr_i   (restart),
      .en_i    (stage_carry),
      .carry_o (line_wrap)
   );

   // R5: a restart coinciding with a wrap merges into one pulse
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         tick_q <= 1'b0;
      end else begin
         tick_q <= restart || line_wrap;
      end
   end

   assign tick_o = tick_q;

endmodule

// File: rtl/restart_clock_gen_chk.sv
module restart_clock_gen_chk #(
   parameter int unsigned PERIOD = 20
) (
   input logic clk_i,
   input logic rst_i,
   input logic done_i,
   input logic tick_o
);

   localparam int unsigned GW = rcg_pkg::cnt_width(PERIOD + 2);

   logic          done_q;
   logic          rise;
   logic [GW-1:0] gap_q;

   always_ff @(posedge clk_i) begin
      done_q <= done_i;
   end

   assign rise = done_i && !done_q;

   // Cycles since the last pulse (or since reset)
   always_ff @(posedge clk_i) begin
      if (rst_i || tick_o) begin
         gap_q <= '0;
      end else if (gap_q != GW'(PERIOD + 1)) begin
         gap_q <= gap_q + 1'b1;
      end
   end

   // R1: reset forces the strobe low
   a_r1_reset_low : assert property (@(posedge clk_i) rst_i |=> !tick_o);

   // R2: never a longer gap than one full period
   a_r2_max_gap : assert property (@(posedge clk_i) disable iff (rst_i)
      gap_q <= GW'(PERIOD));

   // R2 / R4: when the period has fully elapsed a pulse must be present
   a_r4_due_pulse : assert property (@(posedge clk_i) disable iff (rst_i)
      (gap_q == GW'(PERIOD)) |-> tick_o);

   // R3: a completion edge yields a pulse in the next cycle
   a_r3_restart_tick : assert property (@(posedge clk_i) disable iff (rst_i)
      rise |=> tick_o);

   // R8: one-cycle pulse unless a restart edge follows immediately
   a_r8_one_cycle : assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_o && !rise) |=> !tick_o);

endmodule

bind restart_clock_gen restart_clock_gen_chk #(.PERIOD(SECTIONS * STAGES)) u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .done_i (done_i),
   .tick_o (tick_o)
);

// File: tb/test_restart_clock_gen.sv
`timescale 1ns/1ps
module test_restart_clock_gen;

   localparam int unsigned SECTIONS = 2;
   localparam int unsigned STAGES   = 3;
   localparam int unsigned P        = SECTIONS * STAGES;   // R7: 6 cycles
   localparam int          NVEC     = 47;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic done = 1'b0;
   logic tick;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   restart_clock_gen #(.SECTIONS(SECTIONS), .STAGES(STAGES)) i_restart_clock_gen (
      .clk_i  (clk),
      .rst_i  (rst),
      .done_i (done),
      .tick_o (tick)
   );

   // Each entry: {requirement number, done driven before the edge, expected tick after it}
   localparam logic [5:0] VEC [NVEC] = '{
      // R1: first pulse P edges after release
      {4'd1,2'b00},{4'd1,2'b00},{4'd1,2'b00},{4'd1,2'b00},{4'd1,2'b00},{4'd1,2'b01},
      // R2: free-running second period
      {4'd2,2'b00},{4'd2,2'b00},{4'd2,2'b00},{4'd2,2'b00},{4'd2,2'b00},{4'd2,2'b01},
      // R3: completion two edges into a period
      {4'd3,2'b00},{4'd3,2'b00},{4'd3,2'b11},
      // R4: old boundary cancelled, next pulse P after the restart pulse
      {4'd4,2'b00},{4'd4,2'b00},{4'd4,2'b00},{4'd4,2'b00},{4'd4,2'b00},{4'd4,2'b01},
      // R6: done held high only restarts once
      {4'd6,2'b11},{4'd6,2'b10},{4'd6,2'b10},{4'd6,2'b10},{4'd6,2'b10},{4'd6,2'b10},
      {4'd6,2'b11},{4'd6,2'b00},
      // R5: completion on the wrapping edge
      {4'd5,2'b00},{4'd5,2'b00},{4'd5,2'b00},{4'd5,2'b00},{4'd5,2'b11},{4'd5,2'b00},
      {4'd5,2'b00},{4'd5,2'b00},{4'd5,2'b00},{4'd5,2'b00},{4'd5,2'b01},
      // R8: completion right after a natural pulse gives two adjacent pulses
      {4'd8,2'b11},{4'd8,2'b00},{4'd8,2'b00},{4'd8,2'b00},{4'd8,2'b00},{4'd8,2'b00},
      {4'd8,2'b01}
   };

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: tick_o=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", tick, 1'b0);
      rst = 1'b0;

      // Vector table walk
      for (int i = 0; i < NVEC; i++) begin
         done = VEC[i][1];
         @(negedge clk);
         check($sformatf("R%0d step %0d", VEC[i][5:2], i + 1), tick, VEC[i][0]);
      end
      done = 1'b0;

      // R1: reset in mid-period empties the delay line
      repeat (3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R1 reset mid-period", tick, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      for (int k = 1; k <= int'(P); k++) begin
         @(negedge clk);
         check("R1 restart after reset", tick, (k == int'(P)));
      end

      // R6: done held high across reset release is not a completion
      rst  = 1'b1;
      done = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int k = 1; k <= int'(P); k++) begin
         @(negedge clk);
         check("R6 level across reset", tick, (k == int'(P)));
      end

      // R1: reset asserted while the pulse is high clears it
      done = 1'b0;
      rst  = 1'b1;
      @(negedge clk);
      check("R1 reset during pulse", tick, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 quiet after reset", tick, 1'b0);

      summary();
   end

   initial begin
      #(200000 * 10);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      summary();
   end

endmodule